// File: doc/BRIEF.md
# Receive Ring Completion Writer

This block owns the hardware side of a receive descriptor ring. Software fills ring slots with empty buffers, whose byte count is zero, and publishes them by moving a write index. Each incoming transfer arrives as one or more fragments, each with a length and metadata. For every transfer the block takes the slot at its own read index. It writes the received byte count and a flags half-word into that slot's descriptor, then moves the read index on and raises a copy-complete pulse.

A transfer of several fragments is gathered into a single slot and produces one completion. The nonzero byte count in memory is the in-band sign that a slot is filled. The descriptor write is always accepted by memory before the read index moves, so a reader that sees the new index also sees the count. Moving the payload into the buffer is handled elsewhere.

Top module: `rx_ring_completer`

## Requirements
- R1: After reset the read index is 0, no descriptor write is pending, copy-complete and truncation are low, and the transfer input is not ready because the ring is empty.
- R2: A write-index update keeps only the low log2(DEPTH) bits of the written value. Slots between the read index and the write index are available, and the ring is empty when the two are equal.
- R3: While a transfer is offered and no slot is available, the input stays not ready, the overflow-wait output is high and no descriptor write occurs. Once a slot is posted the transfer is taken.
- R4: Each completion is a single 32-bit write to address base + 8*index + 4. Bits [15:0] hold the byte count. Bits [31:16] hold the flags: the metadata id in flag bits [META_W-1:0], the swap status in flag bit 15, and zero in every other flag bit.
- R5: Fragments with the last marker low are accumulated into the same slot. The single write carries the summed length, with the metadata and swap status of the final fragment.
- R6: A summed length above 65535 is written as 65535, and the truncation output pulses together with that transfer's copy-complete pulse.
- R7: A descriptor write, with its address and data, is held unchanged until the memory accepts it. The read index changes only on the clock edge at which a write is accepted.
- R8: Copy-complete is a one-cycle pulse in the cycle after the write is accepted. In that same cycle the read index shows its new value, which wraps from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_base_i | input | ADDR_W | Ring base byte address, 8-byte aligned |
| wr_idx_we_i | input | 1 | Write-index register update strobe |
| wr_idx_i | input | SWIDX_W | Value written to the write-index register |
| rd_idx_o | output | IDX_W | Current read index |
| xfer_valid_i | input | 1 | Fragment offered |
| xfer_ready_o | output | 1 | Fragment accepted when high with valid |
| xfer_len_i | input | LEN_W | Fragment length in bytes |
| xfer_meta_i | input | META_W | Metadata id from the sender |
| xfer_swap_i | input | 1 | Byte-swap status from the sender |
| xfer_last_i | input | 1 | Final fragment of a transfer |
| desc_we_o | output | 1 | Descriptor write request |
| desc_wready_i | input | 1 | Memory accepts the descriptor write |
| desc_addr_o | output | ADDR_W | Descriptor write byte address |
| desc_wdata_o | output | 32 | Flags and byte count |
| cc_irq_o | output | 1 | Copy-complete pulse |
| trunc_err_o | output | 1 | Length-truncation pulse |
| ovf_wait_o | output | 1 | Transfer waiting for a posted buffer |

## Verification
The assertions check several rules on every cycle. A stalled descriptor write must keep its address and data. The read index may move only after an accepted write, and each completion pulse must step it by exactly one. Overflow-wait must never coincide with ready, and truncation must never appear without copy-complete. Other behaviour can only be shown by the bench's scenarios. These include the exact count and flag values written for gathered and oversized transfers, the descriptor addresses across wraparound, and the masking of raw write-index values. They also include backpressure on an empty ring and its release once a buffer is posted.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int unsigned CNT_W      = 16;
  localparam int unsigned FLAG_W     = 16;
  localparam int unsigned DESC_SHIFT = 3;   // 8-byte descriptors
  localparam int unsigned CNT_OFS    = 4;   // count/flags word offset
  localparam int unsigned SWAP_BIT   = 15;
  localparam int unsigned CNT_LIMIT  = 65535;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GATHER = 2'd1,
    ST_WB     = 2'd2
  } rxr_state_e;

  typedef struct packed {
    logic [FLAG_W-1:0] flags;
    logic [CNT_W-1:0]  nbytes;
  } rxr_wb_t;
endpackage

// File: rtl/rxr_idx_ctrl.sv
module rxr_idx_ctrl #(
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned SWIDX_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_we_i,
  input  logic [SWIDX_W-1:0] wr_val_i,
  input  logic               adv_i,
  output logic [IDX_W-1:0]   rd_idx_o,
  output logic               avail_o
);
  localparam logic [SWIDX_W-1:0] IDX_MASK = SWIDX_W'((1 << IDX_W) - 1);

  logic [IDX_W-1:0] wr_q, rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (wr_we_i) wr_q <= IDX_W'(wr_val_i & IDX_MASK);
      if (adv_i)   rd_q <= rd_q + 1'b1;
    end
  end

  assign rd_idx_o = rd_q;
  assign avail_o  = (rd_q != wr_q);

  // never consume a slot software has not posted
  assert_no_overrun_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> avail_o);
endmodule

// File: rtl/rxr_frag_accum.sv
module rxr_frag_accum
  import rxr_pkg::*;
#(
  parameter int unsigned LEN_W  = 20,
  parameter int unsigned META_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              first_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [META_W-1:0] meta_i,
  input  logic              swap_i,
  output rxr_wb_t           wb_o,
  output logic              trunc_o
);
  localparam int unsigned ACC_W = CNT_W + 1;
  localparam int unsigned SUM_W = ((LEN_W > ACC_W) ? LEN_W : ACC_W) + 1;
  localparam logic [SUM_W-1:0] SAT = SUM_W'(CNT_LIMIT + 1);

  logic [ACC_W-1:0]  acc_q;
  logic [META_W-1:0] meta_q;
  logic              swap_q;
  logic [SUM_W-1:0]  sum;

  assign sum = (first_i ? '0 : SUM_W'(acc_q)) + SUM_W'(len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      meta_q <= '0;
      swap_q <= 1'b0;
    end else if (take_i) begin
      acc_q  <= (sum > SAT) ? ACC_W'(SAT) : ACC_W'(sum);
      meta_q <= meta_i;
      swap_q <= swap_i;
    end
  end

  assign trunc_o      = acc_q[CNT_W];
  assign wb_o.nbytes  = trunc_o ? CNT_W'(CNT_LIMIT) : acc_q[CNT_W-1:0];
  assign wb_o.flags   = FLAG_W'(meta_q) | (FLAG_W'(swap_q) << SWAP_BIT);

  assert_acc_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q <= ACC_W'(CNT_LIMIT + 1));
endmodule

// File: rtl/rxr_wb_fsm.sv
module rxr_wb_fsm
  import rxr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xfer_valid_i,
  input  logic xfer_last_i,
  input  logic avail_i,
  input  logic wb_ready_i,
  output logic xfer_ready_o,
  output logic fire_o,
  output logic first_o,
  output logic wb_we_o,
  output logic wb_done_o,
  output logic stall_o
);
  rxr_state_e st_q, st_d;

  assign xfer_ready_o = ((st_q == ST_IDLE) && avail_i) || (st_q == ST_GATHER);
  assign fire_o       = xfer_valid_i && xfer_ready_o;
  assign first_o      = (st_q == ST_IDLE);
  assign wb_we_o      = (st_q == ST_WB);
  assign wb_done_o    = wb_we_o && wb_ready_i;
  assign stall_o      = (st_q == ST_IDLE) && xfer_valid_i && !avail_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (fire_o) st_d = xfer_last_i ? ST_WB : ST_GATHER;
      ST_GATHER: if (fire_o && xfer_last_i) st_d = ST_WB;
      ST_WB:     if (wb_ready_i) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  // a gathered transfer must have reserved a slot before it started
  assert_gather_has_slot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_GATHER) |-> avail_i);
endmodule

// File: rtl/rx_ring_completer.sv
module rx_ring_completer
  import rxr_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LEN_W   = 20,
  parameter int unsigned META_W  = 14,
  parameter int unsigned SWIDX_W = 16,
  localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  cfg_base_i,
  input  logic               wr_idx_we_i,
  input  logic [SWIDX_W-1:0] wr_idx_i,
  output logic [IDX_W-1:0]   rd_idx_o,
  input  logic               xfer_valid_i,
  output logic               xfer_ready_o,
  input  logic [LEN_W-1:0]   xfer_len_i,
  input  logic [META_W-1:0]  xfer_meta_i,
  input  logic               xfer_swap_i,
  input  logic               xfer_last_i,
  output logic               desc_we_o,
  input  logic               desc_wready_i,
  output logic [ADDR_W-1:0]  desc_addr_o,
  output logic [31:0]        desc_wdata_o,
  output logic               cc_irq_o,
  output logic               trunc_err_o,
  output logic               ovf_wait_o
);
  logic    avail, fire, first, wb_done, trunc;
  rxr_wb_t wb;
  logic    cc_q, trunc_q;

  rxr_idx_ctrl #(.IDX_W(IDX_W), .SWIDX_W(SWIDX_W)) u_idx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_we_i  (wr_idx_we_i),
    .wr_val_i (wr_idx_i),
    .adv_i    (wb_done),
    .rd_idx_o (rd_idx_o),
    .avail_o  (avail)
  );

  rxr_frag_accum #(.LEN_W(LEN_W), .META_W(META_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (fire),
    .first_i (first),
    .len_i   (xfer_len_i),
    .meta_i  (xfer_meta_i),
    .swap_i  (xfer_swap_i),
    .wb_o    (wb),
    .trunc_o (trunc)
  );

  rxr_wb_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .xfer_valid_i (xfer_valid_i),
    .xfer_last_i  (xfer_last_i),
    .avail_i      (avail),
    .wb_ready_i   (desc_wready_i),
    .xfer_ready_o (xfer_ready_o),
    .fire_o       (fire),
    .first_o      (first),
    .wb_we_o      (desc_we_o),
    .wb_done_o    (wb_done),
    .stall_o      (ovf_wait_o)
  );

  assign desc_addr_o  = cfg_base_i + (ADDR_W'(rd_idx_o) << DESC_SHIFT) + ADDR_W'(CNT_OFS);
  assign desc_wdata_o = wb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_q    <= 1'b0;
      trunc_q <= 1'b0;
    end else begin
      cc_q    <= wb_done;
      trunc_q <= wb_done && trunc;
    end
  end

  assign cc_irq_o    = cc_q;
  assign trunc_err_o = trunc_q;

  assert_hold_wb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_we_o && !desc_wready_i) |=> (desc_we_o && $stable(desc_addr_o) && $stable(desc_wdata_o)));

  assert_idx_after_wb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rd_idx_o) |-> $past(desc_we_o && desc_wready_i));

  assert_cc_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_irq_o |-> (rd_idx_o == IDX_W'($past(rd_idx_o) + 1'b1)));

  assert_stall_not_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_wait_o |-> (!xfer_ready_o && !desc_we_o));

  assert_trunc_with_cc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trunc_err_o |-> cc_irq_o);

  assert_cc_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_irq_o |=> !cc_irq_o);
endmodule

// File: tb/rx_ring_completer_tb_top.sv
`timescale 1ns/1ps
module rx_ring_completer_tb_top;
  localparam int DEPTH = 16;
  localparam int IDX_W = 4;
  localparam logic [31:0] BASE = 32'h1000_0040;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] cfg_base_i = BASE;
  logic        wr_idx_we_i = 1'b0;
  logic [15:0] wr_idx_i = '0;
  logic [IDX_W-1:0] rd_idx_o;
  logic        xfer_valid_i = 1'b0;
  logic        xfer_ready_o;
  logic [19:0] xfer_len_i = '0;
  logic [13:0] xfer_meta_i = '0;
  logic        xfer_swap_i = 1'b0;
  logic        xfer_last_i = 1'b0;
  logic        desc_we_o;
  logic        desc_wready_i = 1'b1;
  logic [31:0] desc_addr_o;
  logic [31:0] desc_wdata_o;
  logic        cc_irq_o, trunc_err_o, ovf_wait_o;

  always #2.5 clk_i = ~clk_i;

  rx_ring_completer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_base_i(cfg_base_i),
    .wr_idx_we_i(wr_idx_we_i), .wr_idx_i(wr_idx_i), .rd_idx_o(rd_idx_o),
    .xfer_valid_i(xfer_valid_i), .xfer_ready_o(xfer_ready_o),
    .xfer_len_i(xfer_len_i), .xfer_meta_i(xfer_meta_i),
    .xfer_swap_i(xfer_swap_i), .xfer_last_i(xfer_last_i),
    .desc_we_o(desc_we_o), .desc_wready_i(desc_wready_i),
    .desc_addr_o(desc_addr_o), .desc_wdata_o(desc_wdata_o),
    .cc_irq_o(cc_irq_o), .trunc_err_o(trunc_err_o), .ovf_wait_o(ovf_wait_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit stall_mode = 0;

  logic [31:0] exp_data [0:511];
  logic        exp_tr   [0:511];
  int push_p = 0, pop_p = 0;
  int done_cnt = 0, posted = 0, sw_wr = 0, exp_rd = 0;
  bit stage_cc = 0, stage_low = 0, pend_tr = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R4/R6: expected count and flags word
  function automatic logic [31:0] wb_word(input int total, input logic [13:0] meta, input logic swap);
    logic [15:0] cnt;
    cnt = (total > 65535) ? 16'hFFFF : 16'(total);
    return {swap, 1'b0, meta, cnt};
  endfunction

  // all driving happens 1 ns after a rising edge
  task automatic post(input int n);
    sw_wr = (sw_wr + n) % DEPTH;
    wr_idx_we_i = 1'b1;
    wr_idx_i = 16'(sw_wr + DEPTH * ($urandom % 4));  // R2: upper bits ignored
    posted += n;
    @(posedge clk_i); #1;
    wr_idx_we_i = 1'b0;
  endtask

  task automatic frag(input logic [19:0] len, input logic [13:0] meta, input logic swap, input logic last);
    bit acc;
    xfer_valid_i = 1'b1; xfer_len_i = len; xfer_meta_i = meta;
    xfer_swap_i = swap;  xfer_last_i = last;
    do begin
      @(negedge clk_i); acc = xfer_ready_o;
      @(posedge clk_i); #1;
    end while (!acc);
    xfer_valid_i = 1'b0;
  endtask

  task automatic send(input int n, input logic [19:0] l0, input logic [19:0] l1,
                      input logic [19:0] l2, input logic [13:0] meta, input logic swap);
    int total;
    logic [19:0] l [3];
    l[0] = l0; l[1] = l1; l[2] = l2;
    total = 0;
    for (int i = 0; i < n; i++) total += int'(l[i]);
    exp_data[push_p % 512] = wb_word(total, meta, swap);
    exp_tr[push_p % 512]   = (total > 65535);
    push_p++;
    for (int i = 0; i < n; i++)
      if (i == n - 1) frag(l[i], meta, swap, 1'b1);
      else            frag(l[i], ~meta, ~swap, 1'b0);
  endtask

  task automatic wait_done(input int target);
    while (done_cnt < target) @(posedge clk_i);
    repeat (3) @(posedge clk_i);
    #1;
  endtask

  // descriptor write monitor
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      if (stage_cc) begin
        chk("R8 cc pulse", 32'(cc_irq_o), 32'd1);
        chk("R8 rd index", 32'(rd_idx_o), 32'(exp_rd));
        chk("R6 trunc flag", 32'(trunc_err_o), 32'(pend_tr));
        stage_cc = 0; stage_low = 1;
      end else if (stage_low) begin
        chk("R8 cc one cycle", 32'(cc_irq_o), 32'd0);
        stage_low = 0;
      end
      if (desc_we_o && desc_wready_i) begin
        if (pop_p >= push_p) begin
          chk("R7 unexpected write", 32'd1, 32'd0);
        end else begin
          chk("R4 desc address", desc_addr_o, BASE + 32'(exp_rd * 8 + 4));
          chk("R4 R5 desc data", desc_wdata_o, exp_data[pop_p % 512]);
          chk("R7 index held", 32'(rd_idx_o), 32'(exp_rd));
          pend_tr = exp_tr[pop_p % 512];
          pop_p++;
        end
        exp_rd = (exp_rd + 1) % DEPTH;
        done_cnt++;
        stage_cc = 1;
      end
    end
  end

  // write-accept pacing
  initial begin
    forever begin
      @(posedge clk_i); #1;
      desc_wready_i = stall_mode ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_1234);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 reset rd index", 32'(rd_idx_o), 32'd0);
    chk("R1 reset no write", 32'(desc_we_o), 32'd0);
    chk("R1 reset cc", 32'(cc_irq_o), 32'd0);
    chk("R1 reset trunc", 32'(trunc_err_o), 32'd0);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 empty ring not ready", 32'(xfer_ready_o), 32'd0);
    @(posedge clk_i); #1;

    // R2: raw value DEPTH+3 posts three slots
    wr_idx_we_i = 1'b1; wr_idx_i = 16'(DEPTH + 3);
    @(posedge clk_i); #1;
    wr_idx_we_i = 1'b0; sw_wr = 3; posted = 3;
    send(1, 20'd100, 0, 0, 14'h0123, 1'b0);
    send(1, 20'd65535, 0, 0, 14'h3FFF, 1'b1);   // R6 boundary, no truncation
    send(1, 20'd1, 0, 0, 14'h0001, 1'b1);
    wait_done(3);

    // R3: ring empty again, transfer must wait
    xfer_valid_i = 1'b1; xfer_len_i = 20'd77; xfer_meta_i = 14'h0AA;
    xfer_swap_i = 1'b0; xfer_last_i = 1'b1;
    exp_data[push_p % 512] = wb_word(77, 14'h0AA, 1'b0);
    exp_tr[push_p % 512] = 1'b0;
    push_p++;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk("R2 R3 stalled not ready", 32'(xfer_ready_o), 32'd0);
      chk("R3 overflow wait", 32'(ovf_wait_o), 32'd1);
      chk("R3 no write while empty", 32'(desc_we_o), 32'd0);
      @(posedge clk_i); #1;
    end
    sw_wr = 4; posted = 4;
    wr_idx_we_i = 1'b1; wr_idx_i = 16'd4;
    @(posedge clk_i); #1;
    wr_idx_we_i = 1'b0;
    @(negedge clk_i);
    chk("R3 released ready", 32'(xfer_ready_o), 32'd1);
    chk("R3 wait cleared", 32'(ovf_wait_o), 32'd0);
    @(posedge clk_i); #1;
    xfer_valid_i = 1'b0;
    wait_done(4);

    // R5: gather into one slot
    post(1);
    send(3, 20'd100, 20'd200, 20'd300, 14'h02AB, 1'b1);
    wait_done(5);
    // R6: gathered and single oversized transfers
    post(2);
    send(3, 20'd30000, 20'd30000, 20'd30000, 14'h0155, 1'b0);
    send(1, 20'd70000, 0, 0, 14'h1000, 1'b1);
    wait_done(7);

    // mixed random traffic with write stalls, crosses wrap several times
    stall_mode = 1;
    for (int t = 0; t < 250; t++) begin
      int n;
      logic [19:0] l [3];
      if (posted - done_cnt < 2) post(1 + ($urandom % 3));
      n = 1 + ($urandom % 3);
      for (int i = 0; i < 3; i++)
        l[i] = (($urandom % 8) == 0) ? 20'(20000 + ($urandom % 20000))
                                     : 20'(1 + ($urandom % 2000));
      send(n, l[0], l[1], l[2], 14'($urandom), 1'($urandom));
    end
    wait_done(push_p);
    chk("R8 total completions", 32'(done_cnt), 32'(push_p));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule